// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a two-colour pointer on top of a pixel stream that is on its way to the display. Software programs it one byte at a time through an index/data register pair. The registers cover the pointer's horizontal and vertical position, an on/off bit, a choice between a 32x32 and a 64x64 pointer, and a slot number. The slot number selects which 256-byte pattern in the top 16 KB of video memory is used.

Before each display line starts, the raster logic pulses `line_start` and gives the number of the coming line. If that line crosses the pointer, the block reads the line's two bit planes from video memory through a single synchronous read port. The read data arrives one cycle after the request.

While the line is being displayed, every valid pixel inside the pointer window is changed according to its two pattern bits:
- a set mask bit clears the pixel to black;
- a set invert bit then flips every bit of the pixel.

All other pixels pass through unchanged. Every pixel leaves the block one cycle after it enters.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, the index readback is 0x00, `out_vld` and `pix_out` are 0, `mem_rd` is low and the pointer is off.
- R2: A data write when the index's bits [4:0] equal 0x10 loads X with {data, index[7:5]}. When they equal 0x11, it loads Y the same way.
- R3: A data write at index 0x12 sets the pointer enable from bit 0 and the 64x64 size from bit 2. When bit 0 is clear, no pixel is changed and no line is fetched.
- R4: The pattern base is (2^VRAM_AW - 16384) + 256 x slot. The slot is written at index 0x13, bits [5:0]. In 64x64 mode, slot bits [1:0] are treated as zero. A write to either index 0x12 or index 0x13 updates the base using both values.
- R5: In 32x32 mode, the mask and invert bytes of pointer row r come from different places. The invert plane (4 bytes) starts at base + 4r. The mask plane starts 128 bytes after that.
- R6: In 64x64 mode, pointer row r occupies 16 bytes starting at base + 16r. Bytes 0-7 are the invert plane and bytes 8-15 are the mask plane.
- R7: Pointer column c takes bit 7 - (c mod 8) of byte c/8 of each plane.
- R8: A set mask bit makes the pixel zero. A set invert bit then XORs the pixel with all ones.
- R9: A pixel passes unchanged when it is outside the window [X, X+size) x [Y, Y+size), or when `pix_vld` is low.
- R10: `pix_out` and `out_vld` follow `pix_in` and `pix_vld` with exactly one cycle of delay.
- R11: Readback of the index behaves as follows:
  - Writing a byte at index 0x06 whose value under mask 0x17 equals 0x12 unlocks the readback.
  - While unlocked, an index whose bits [4:1] are 0b1000 reads back as {position[2:0], 0b1000, index[0]}. The position is X when index[0] is 0 and Y when it is 1.
  - Any other index, or any index while locked, reads back unchanged.
- R12: A `line_start` for a line inside the window issues one read per cycle, in plane-then-byte order: 8 reads in 32x32 mode, 16 in 64x64 mode. A line outside the window issues none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Load the register index |
| idx_wdata | input | 8 | New index value |
| dat_we | input | 1 | Write data to the currently indexed register |
| dat_wdata | input | 8 | Register data |
| idx_rdata | output | 8 | Index readback |
| line_start | input | 1 | Pulse during blanking, before the line's first pixel |
| line_y | input | 11 | Number of the line announced by `line_start` |
| pix_x | input | 11 | Column of the incoming pixel |
| pix_vld | input | 1 | Incoming pixel is valid |
| pix_in | input | PIX_W | Incoming pixel |
| mem_rd | output | 1 | Video memory read request |
| mem_addr | output | VRAM_AW | Video memory byte address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| out_vld | output | 1 | Delayed valid strobe |
| pix_out | output | PIX_W | Overlaid pixel |

## Verification
The bench covers both edges of the window in each direction: one column and one line outside, and the last column and line inside. An off-by-one window would either overwrite a neighbouring pixel or drop the pointer's edge.

It checks the plane layout of both sizes by comparing each read address. A design that swaps the plane offsets, or ignores the forced slot bits in 64x64 mode, would fetch the wrong bytes and paint a scrambled pointer.

It writes the size and slot registers in both orders, to catch a base that is recomputed from only one of them. It also reads the position index through a mirror index, both locked and unlocked, to catch readback that returns the raw index or ignores the unlock mask.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int VRAM_AW = 20,
  parameter int PIX_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic [7:0]         idx_wdata,
  input  logic               dat_we,
  input  logic [7:0]         dat_wdata,
  output logic [7:0]         idx_rdata,
  input  logic               line_start,
  input  logic [10:0]        line_y,
  input  logic [10:0]        pix_x,
  input  logic               pix_vld,
  input  logic [PIX_W-1:0]   pix_in,
  output logic               mem_rd,
  output logic [VRAM_AW-1:0] mem_addr,
  input  logic [7:0]         mem_rdata,
  output logic               out_vld,
  output logic [PIX_W-1:0]   pix_out
);
  localparam logic [VRAM_AW-1:0] PAT_TOP = {{(VRAM_AW-14){1'b1}}, 14'd0};

  logic [7:0]         idx_q;
  logic               unl_q, en_q, big_q;
  logic [10:0]        cx_q, cy_q;
  logic [5:0]         slot_q;
  logic [VRAM_AW-1:0] base_q;

  function automatic logic [VRAM_AW-1:0] slot_base(input logic big, input logic [5:0] slot);
    logic [5:0] s;
    s = big ? {slot[5:2], 2'b00} : slot;
    return PAT_TOP + {{(VRAM_AW-14){1'b0}}, s, 8'd0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      unl_q  <= 1'b0;
      en_q   <= 1'b0;
      big_q  <= 1'b0;
      cx_q   <= '0;
      cy_q   <= '0;
      slot_q <= '0;
      base_q <= PAT_TOP;
    end else begin
      if (dat_we) begin
        if (idx_q == 8'h06) unl_q <= (dat_wdata & 8'h17) == 8'h12;
        if (idx_q[4:0] == 5'h10) cx_q <= {dat_wdata, idx_q[7:5]};
        if (idx_q[4:0] == 5'h11) cy_q <= {dat_wdata, idx_q[7:5]};
        if (idx_q == 8'h12) begin
          en_q   <= dat_wdata[0];
          big_q  <= dat_wdata[2];
          base_q <= slot_base(dat_wdata[2], slot_q);
        end
        if (idx_q == 8'h13) begin
          slot_q <= dat_wdata[5:0];
          base_q <= slot_base(big_q, dat_wdata[5:0]);
        end
      end
      if (idx_we) idx_q <= idx_wdata;
    end
  end

  assign idx_rdata = (unl_q && idx_q[4:1] == 4'b1000)
                   ? {(idx_q[0] ? cy_q[2:0] : cx_q[2:0]), 4'b1000, idx_q[0]}
                   : idx_q;

  logic [10:0] row;
  logic        row_hit;
  logic [9:0]  row_off;
  assign row     = line_y - cy_q;
  assign row_hit = en_q && (line_y >= cy_q) && (row < (big_q ? 11'd64 : 11'd32));
  assign row_off = big_q ? {row[5:0], 4'b0000} : {3'b000, row[4:0], 2'b00};

  logic               fetch_q, lbig_q, lhit_q, cap_q;
  logic [3:0]         k_q, capk_q;
  logic [VRAM_AW-1:0] laddr_q;
  logic [63:0]        p0_q, p1_q;
  logic [7:0]         koff;
  logic               k_last;

  assign koff     = lbig_q ? {4'b0000, k_q} : {k_q[2], 5'b00000, k_q[1:0]};
  assign k_last   = lbig_q ? (k_q == 4'd15) : (k_q == 4'd7);
  assign mem_rd   = fetch_q;
  assign mem_addr = laddr_q + {{(VRAM_AW-8){1'b0}}, koff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      lbig_q  <= 1'b0;
      lhit_q  <= 1'b0;
      k_q     <= '0;
      laddr_q <= '0;
      cap_q   <= 1'b0;
      capk_q  <= '0;
    end else begin
      cap_q  <= fetch_q;
      capk_q <= k_q;
      if (line_start) begin
        lhit_q  <= row_hit;
        lbig_q  <= big_q;
        fetch_q <= row_hit;
        k_q     <= '0;
        laddr_q <= base_q + {{(VRAM_AW-10){1'b0}}, row_off};
      end else if (fetch_q) begin
        k_q <= k_q + 4'd1;
        if (k_last) fetch_q <= 1'b0;
      end
    end
  end

  logic [2:0] capb;
  logic       cap_pl;
  assign capb   = lbig_q ? capk_q[2:0] : {1'b0, capk_q[1:0]};
  assign cap_pl = lbig_q ? capk_q[3] : capk_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= '0;
      p1_q <= '0;
    end else if (cap_q) begin
      for (int i = 0; i < 8; i++) begin
        if (capb == 3'(i)) begin
          if (cap_pl) p1_q[8*(7-i) +: 8] <= mem_rdata;
          else        p0_q[8*(7-i) +: 8] <= mem_rdata;
        end
      end
    end
  end

  logic [11:0]      cdiff;
  logic             in_win, inv_bit, blk_bit;
  logic [5:0]       col;
  logic [PIX_W-1:0] nxt;
  assign cdiff   = {1'b0, pix_x} - {1'b0, cx_q};
  assign col     = cdiff[5:0];
  assign in_win  = en_q && lhit_q && pix_vld && !cdiff[11]
                && (cdiff[10:0] < (lbig_q ? 11'd64 : 11'd32));
  assign inv_bit = p0_q[~col];
  assign blk_bit = p1_q[~col];
  assign nxt     = in_win ? ((blk_bit ? '0 : pix_in) ^ {PIX_W{inv_bit}}) : pix_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out <= '0;
      out_vld <= 1'b0;
    end else begin
      pix_out <= nxt;
      out_vld <= pix_vld;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int VRAM_AW = 20,
  parameter int PIX_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_vld,
  input logic [PIX_W-1:0]   pix_in,
  input logic               out_vld,
  input logic [PIX_W-1:0]   pix_out,
  input logic               mem_rd,
  input logic [VRAM_AW-1:0] mem_addr,
  input logic               cur_en
);
  localparam logic [VRAM_AW-1:0] TOP_ADDR = {{(VRAM_AW-14){1'b1}}, 14'd0};

  a_r10_vld_rise: assert property (@(posedge clk) disable iff (!rst_n) pix_vld |=> out_vld);
  a_r10_vld_fall: assert property (@(posedge clk) disable iff (!rst_n) !pix_vld |=> !out_vld);
  a_r9_pass_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> pix_out == $past(pix_in));
  a_r3_pass_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> pix_out == $past(pix_in));
  a_r4_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr >= TOP_ADDR);
endmodule

bind cursor_overlay cursor_overlay_chk #(.VRAM_AW(VRAM_AW), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_in), .out_vld(out_vld),
  .pix_out(pix_out), .mem_rd(mem_rd), .mem_addr(mem_addr), .cur_en(en_q)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  localparam int AW  = 20;
  localparam int PW  = 24;
  localparam int TOP = (1 << AW) - 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          idx_we = 0, dat_we = 0, line_start = 0, pix_vld = 0;
  logic [7:0]    idx_wdata = 0, dat_wdata = 0, idx_rdata, mem_rdata;
  logic [10:0]   line_y = 0, pix_x = 0;
  logic [PW-1:0] pix_in = 0, pix_out;
  logic          mem_rd, out_vld;
  logic [AW-1:0] mem_addr;

  cursor_overlay #(.VRAM_AW(AW), .PIX_W(PW)) u0 (.*);

  function automatic logic [7:0] fb(int a);
    return 8'((a * 29) ^ (a >> 5) ^ 'h6b);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= fb(int'(mem_addr));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_idx = 0, m_cx = 0, m_cy = 0, m_en = 0, m_big = 0, m_slot = 0, m_unl = 0, cur_y = 0;
  int q[$];
  bit d_ls, d_vld, d_iwe, d_dwe;
  int d_ly, d_x, d_iw, d_dw;
  logic [PW-1:0] d_in, e_pix;
  bit have_exp = 0, e_vld;
  string e_tag;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_base();
    return TOP + 256 * (m_big ? (m_slot & 'h3c) : (m_slot & 'h3f));
  endfunction

  function automatic logic [PW-1:0] model_pix(int x, bit vld, logic [PW-1:0] pin, output string tag);
    int size, r, c, ra, b0, b1;
    logic [PW-1:0] res;
    size = m_big ? 64 : 32;
    tag = "R9";
    if (!vld || !m_en) return pin;
    if (cur_y < m_cy || cur_y >= m_cy + size || x < m_cx || x >= m_cx + size) return pin;
    r = cur_y - m_cy; c = x - m_cx;
    if (m_big) begin
      ra = m_base() + 16 * r; b0 = fb(ra + c / 8); b1 = fb(ra + 8 + c / 8); tag = "R2 R3 R6 R7 R8";
    end else begin
      ra = m_base() + 4 * r;  b0 = fb(ra + c / 8); b1 = fb(ra + 128 + c / 8); tag = "R2 R5 R7 R8";
    end
    res = b1[7 - c % 8] ? '0 : pin;
    if (b0[7 - c % 8]) res = ~res;
    return res;
  endfunction

  function automatic int exp_idx();
    if (m_unl && (m_idx & 'h1e) == 'h10)
      return ((((m_idx & 1) ? m_cy : m_cx) & 7) << 5) | 'h10 | (m_idx & 1);
    return m_idx;
  endfunction

  task automatic clr();
    d_ls = 0; d_vld = 0; d_iwe = 0; d_dwe = 0; d_ly = 0; d_x = 0; d_iw = 0; d_dw = 0; d_in = '0;
  endtask

  task automatic step();
    @(negedge clk);
    if (have_exp) begin
      check(pix_out === e_pix, e_tag, pix_out, e_pix);
      check(out_vld === e_vld, "R10", out_vld, e_vld);
    end
    if (mem_rd) begin
      if (q.size() == 0) check(0, "R12", mem_addr, -1);
      else begin
        int a = q.pop_front();
        check(int'(mem_addr) == a, "R4 R12", mem_addr, a);
      end
    end
    line_start = d_ls; line_y = 11'(d_ly); pix_vld = d_vld; pix_x = 11'(d_x); pix_in = d_in;
    idx_we = d_iwe; idx_wdata = 8'(d_iw); dat_we = d_dwe; dat_wdata = 8'(d_dw);
    if (d_ls) begin
      int size = m_big ? 64 : 32;
      int r = d_ly - m_cy;
      if (m_en && d_ly >= m_cy && r < size) begin
        for (int k = 0; k < (m_big ? 16 : 8); k++)
          q.push_back(m_big ? m_base() + 16 * r + k
                            : m_base() + 4 * r + (k < 4 ? k : 128 + k - 4));
      end
    end
    e_pix = model_pix(d_x, d_vld, d_in, e_tag);
    e_vld = d_vld; have_exp = 1;
    if (d_dwe) begin
      if (m_idx == 6) m_unl = ((d_dw & 'h17) == 'h12);
      if ((m_idx & 'h1f) == 'h10) m_cx = d_dw * 8 + (m_idx >> 5);
      if ((m_idx & 'h1f) == 'h11) m_cy = d_dw * 8 + (m_idx >> 5);
      if (m_idx == 'h12) begin m_en = d_dw & 1; m_big = (d_dw >> 2) & 1; end
      if (m_idx == 'h13) m_slot = d_dw & 'h3f;
    end
    if (d_iwe) m_idx = d_iw;
  endtask

  task automatic wr(int idx, int data);
    clr(); d_iwe = 1; d_iw = idx; step();
    clr(); d_dwe = 1; d_dw = data; step();
    clr(); step();
  endtask

  task automatic set_idx(int idx);
    clr(); d_iwe = 1; d_iw = idx; step();
    clr(); step();
    check(int'(idx_rdata) == exp_idx(), "R11", idx_rdata, exp_idx());
  endtask

  task automatic line(int y);
    int x0, x1;
    cur_y = y;
    clr(); d_ls = 1; d_ly = y; step();
    clr(); repeat (20) step();
    check(q.size() == 0, "R12", q.size(), 0);
    x0 = (m_cx > 2) ? m_cx - 2 : 0;
    x1 = m_cx + (m_big ? 64 : 32) + 1;
    for (int x = x0; x <= x1; x++) begin
      clr(); d_vld = (x != m_cx + 1); d_x = x;
      d_in = PW'(x * 977 + y * 131 + 'h123456);
      step();
    end
    clr(); step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idx_rdata == 8'h00, "R1", idx_rdata, 0);
    check(out_vld == 1'b0, "R1", out_vld, 0);
    check(pix_out == '0, "R1", pix_out, 0);
    check(mem_rd == 1'b0, "R1", mem_rd, 0);
    rst_n = 1'b1;
    line(5);
    wr(6, 'h3A);
    wr('h30, 'h0C);
    wr('h71, 'h02);
    set_idx('hF0);
    set_idx('h51);
    set_idx('h13);
    wr(6, 'h00);
    set_idx('hF0);
    wr(6, 'h12);
    wr('h13, 5);
    wr('h12, 1);
    for (int y = m_cy - 1; y <= m_cy + 32; y++) line(y);
    wr('h13, 7);
    wr('h12, 5);
    for (int y = m_cy - 1; y <= m_cy + 64; y++) line(y);
    wr('h12, 4);
    line(m_cy + 1);
    wr('h12, 5);
    wr('h13, 'h2B);
    line(m_cy);
    line(m_cy + 63);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule